// File: doc/BRIEF.md
# Embedded Operation Status Reporter

This block forms the word that a host reads back from a flash-style memory while an embedded program or erase runs. It also drives a ready/busy line. The command decoder and the write-state sequencer sit outside it. They tell the block five things: which operation is running, whether it is busy, the target value of the polled data bit, whether an erase is suspended, and whether the sector-erase acceptance window is still open. A one-cycle pulse reports that the internal pulse counter has gone past its limit. A read strobe marks each status read by the host.

While an operation is active, the host does not see array contents. It sees a status word instead:
- a polling bit that reads the complement of the final value until the operation is done;
- a toggle bit that flips on every status read;
- a sticky time-limit error bit;
- a window-closed bit for erase operations.

When the block is idle or suspended, the array data passes straight through. This lets the host read sectors that are not being erased. The ready/busy line is low only while an operation is actively running.

Top module: `op_status_reporter`

## Requirements
- R1: While `busy` is low, `dout` equals `array_data` and `rdy` is high; this is also the state straight after reset.
- R2: While busy and not suspended, bit 7 of `dout` is the complement of `target_bit` when `op_kind` is 2'b01 (program), and 0 for 2'b10 (sector erase), 2'b11 (chip erase) or 2'b00.
- R3: While busy and not suspended, bit 6 of `dout` inverts once for each low-to-high transition of `rd_strobe`, in the clock edge that first samples it high; holding the strobe high causes no further change.
- R4: Any clock edge that samples `busy` low returns bit 6 to 0, so a new operation starts with bit 6 at 0.
- R5: While `suspended` is high, strobe rises do not change the toggle state; after the suspend ends, bit 6 shows the value it had before the suspend.
- R6: A `pulse_over` pulse that is sampled while busy and not suspended sets bit 5. Bit 5 then stays set across clock edges and across the end of the operation until `clear_err` is sampled high. `clear_err` wins over a simultaneous set.
- R7: While busy and not suspended, bit 3 of `dout` is 1 when `op_kind` is an erase (2'b10 or 2'b11) and `window_open` is low, and 0 otherwise.
- R8: While busy and not suspended, bits 4, 2, 1 and 0 (and any bits above 7) of `dout` read 0.
- R9: `rdy` is low exactly when `busy` is high and `suspended` is low.
- R10: While busy and suspended, `dout` equals `array_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_kind | input | 2 | Running operation: 00 none, 01 program, 10 sector erase, 11 chip erase |
| busy | input | 1 | An embedded operation is in progress |
| suspended | input | 1 | The erase suspend has taken effect |
| target_bit | input | 1 | Bit 7 of the data being programmed |
| window_open | input | 1 | The sector-erase acceptance window is still open |
| pulse_over | input | 1 | The pulse counter has exceeded its limit (one-cycle pulse) |
| clear_err | input | 1 | A reset command or a resume clears the time-limit error |
| rd_strobe | input | 1 | Level that is high during a host status read |
| array_data | input | DATA_W | Data read from the array |
| dout | output | DATA_W | Read data: the status word or the array data |
| rdy | output | 1 | Ready (high) or busy (low) |

## Verification
The bench goes after these corner cases:
- **Held read strobe.** A design that flips the toggle on a level instead of an edge would show bit 6 changing twice for one long read.
- **Strobes during a suspend.** A design that keeps counting reads while suspended would return a different bit 6 after the resume.
- **Error bit.** A design that clears the error when the operation ends, or lets a set beat a clear in the same cycle, would miscompare bit 5.
- **Full sweep.** The bench sweeps every combination of operation type, busy, suspend, target bit and window state. This catches a polling bit with the wrong sense for erase, a window bit shown during a program, and array data leaking into the status word.

// File: rtl/opstat_pkg.sv
package opstat_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_PROG = 2'b01,
    OP_SECT = 2'b10,
    OP_CHIP = 2'b11
  } op_kind_e;

  localparam int POLL_POS = 7;
  localparam int TOG_POS  = 6;
  localparam int ERR_POS  = 5;
  localparam int WIN_POS  = 3;

  function automatic logic is_erase(op_kind_e k);
    return (k == OP_SECT) || (k == OP_CHIP);
  endfunction

  // The polling bit reads the opposite of the final value while work is pending.
  // An erase drives every bit to 1, so the pending value for an erase is 0.
  function automatic logic poll_value(op_kind_e k, logic tgt);
    return (k == OP_PROG) ? ~tgt : 1'b0;
  endfunction

  function automatic logic window_value(op_kind_e k, logic win_open);
    return is_erase(k) && !win_open;
  endfunction

endpackage

// File: rtl/rise_detect.sv
module rise_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic rise
);
  logic level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level;
  end

  assign rise = level & ~level_q;
endmodule

// File: rtl/toggle_track.sv
module toggle_track (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic frozen,
  input  logic advance,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  q <= 1'b0;
    else if (!active)            q <= 1'b0;
    else if (advance && !frozen) q <= ~q;
  end
endmodule

// File: rtl/err_latch.sv
module err_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (clr) q <= 1'b0;
    else if (set) q <= 1'b1;
  end
endmodule

// File: rtl/status_compose.sv
module status_compose
  import opstat_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  op_kind_e          kind,
  input  logic              busy,
  input  logic              suspended,
  input  logic              target_bit,
  input  logic              window_open,
  input  logic              tog,
  input  logic              err,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] dout,
  output logic              rdy
);
  logic              poll;
  logic              win;
  logic              show_status;
  logic [DATA_W-1:0] word;

  assign poll        = poll_value(kind, target_bit);
  assign win         = window_value(kind, window_open);
  assign show_status = busy && !suspended;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i == POLL_POS)     begin : g_poll assign word[i] = poll; end
    else if (i == TOG_POS) begin : g_tog  assign word[i] = tog;  end
    else if (i == ERR_POS) begin : g_err  assign word[i] = err;  end
    else if (i == WIN_POS) begin : g_win  assign word[i] = win;  end
    else                   begin : g_zero assign word[i] = 1'b0; end
  end

  assign dout = show_status ? word : array_data;
  assign rdy  = !show_status;
endmodule

// File: rtl/op_status_reporter.sv
module op_status_reporter
  import opstat_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        op_kind,
  input  logic              busy,
  input  logic              suspended,
  input  logic              target_bit,
  input  logic              window_open,
  input  logic              pulse_over,
  input  logic              clear_err,
  input  logic              rd_strobe,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] dout,
  output logic              rdy
);
  op_kind_e kind;
  logic     rd_rise;
  logic     tog_q;
  logic     err_q;
  logic     err_set;

  assign kind    = op_kind_e'(op_kind);
  assign err_set = pulse_over && busy && !suspended;

  rise_detect u_rise (
    .clk   (clk),
    .rst_n (rst_n),
    .level (rd_strobe),
    .rise  (rd_rise)
  );

  toggle_track u_tog (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (busy),
    .frozen  (suspended),
    .advance (rd_rise),
    .q       (tog_q)
  );

  err_latch u_err (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (err_set),
    .clr   (clear_err),
    .q     (err_q)
  );

  status_compose #(.DATA_W(DATA_W)) u_comp (
    .kind        (kind),
    .busy        (busy),
    .suspended   (suspended),
    .target_bit  (target_bit),
    .window_open (window_open),
    .tog         (tog_q),
    .err         (err_q),
    .array_data  (array_data),
    .dout        (dout),
    .rdy         (rdy)
  );
endmodule

// File: rtl/op_status_checker.sv
module op_status_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        op_kind,
  input logic              busy,
  input logic              suspended,
  input logic              target_bit,
  input logic              pulse_over,
  input logic              clear_err,
  input logic [DATA_W-1:0] array_data,
  input logic [DATA_W-1:0] dout,
  input logic              rdy,
  input logic              rd_rise,
  input logic              tog_q,
  input logic              err_q
);
  assert_idle_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (dout == array_data) && rdy);

  assert_poll_prog_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !suspended && op_kind == 2'b01) |-> dout[7] == ~target_bit);

  assert_poll_erase_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !suspended && op_kind[1]) |-> !dout[7]);

  assert_toggle_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !suspended && rd_rise) |=> tog_q != $past(tog_q));

  assert_toggle_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !tog_q);

  assert_toggle_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && suspended) |=> tog_q == $past(tog_q));

  assert_err_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !clear_err) |=> err_q);

  assert_err_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_over && busy && !suspended && !clear_err) |=> err_q);

  assert_err_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clear_err |=> !err_q);

  assert_spare_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !suspended) |-> (dout[4] == 1'b0) && (dout[2:0] == 3'b000));

  assert_rdy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rdy == (!busy || suspended));

  assert_suspend_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && suspended) |-> dout == array_data);
endmodule

bind op_status_reporter op_status_checker #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_kind    (op_kind),
  .busy       (busy),
  .suspended  (suspended),
  .target_bit (target_bit),
  .pulse_over (pulse_over),
  .clear_err  (clear_err),
  .array_data (array_data),
  .dout       (dout),
  .rdy        (rdy),
  .rd_rise    (rd_rise),
  .tog_q      (tog_q),
  .err_q      (err_q)
);

// File: tb/op_status_reporter_test.sv
`timescale 1ns/1ps
module op_status_reporter_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] op_kind;
  logic       busy, suspended, target_bit, window_open;
  logic       pulse_over, clear_err, rd_strobe;
  logic [7:0] array_data;
  logic [7:0] dout;
  logic       rdy;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  op_status_reporter #(.DATA_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .op_kind(op_kind), .busy(busy),
    .suspended(suspended), .target_bit(target_bit), .window_open(window_open),
    .pulse_over(pulse_over), .clear_err(clear_err), .rd_strobe(rd_strobe),
    .array_data(array_data), .dout(dout), .rdy(rdy)
  );

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // Status word predicted from the requirement text.
  function automatic logic [7:0] status_of(input logic [1:0] k, input logic tgt,
                                           input logic win, input logic tg, input logic er);
    logic p, w;
    p = (k == 2'b01) ? !tgt : 1'b0;
    w = (k[1] == 1'b1) && !win;
    return {p, tg, er, 1'b0, w, 3'b000};
  endfunction

  task automatic strobe_read();
    rd_strobe = 1'b1;
    step();
    rd_strobe = 1'b1;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; op_kind = 2'b00; busy = 1'b0; suspended = 1'b0;
    target_bit = 1'b0; window_open = 1'b0; pulse_over = 1'b0;
    clear_err = 1'b0; rd_strobe = 1'b0; array_data = 8'hA5;
    repeat (3) step();
    check("R1 reset", {rdy, dout}, {1'b1, 8'hA5});
    rst_n = 1'b1;
    step();

    // Sweep: toggle and error state stay 0 throughout.
    for (int k = 0; k < 4; k++)
      for (int b = 0; b < 2; b++)
        for (int s = 0; s < 2; s++)
          for (int t = 0; t < 2; t++)
            for (int w = 0; w < 2; w++) begin
              logic [7:0] a;
              logic [7:0] e;
              a = 8'((k * 61) + (b * 29) + (s * 13) + (t * 7) + (w * 3) + 8'h40);
              step();
              op_kind = 2'(k); busy = 1'(b); suspended = 1'(s);
              target_bit = 1'(t); window_open = 1'(w); array_data = a;
              #1;
              e = (b == 1 && s == 0) ? status_of(2'(k), 1'(t), 1'(w), 1'b0, 1'b0) : a;
              check("R1 R2 R7 R8 R10 sweep", {1'b0, dout}, {1'b0, e});
              check("R9 sweep", {8'h00, rdy}, {8'h00, !(b == 1 && s == 0)});
            end

    // Toggle behaviour during a program with target 1.
    step();
    op_kind = 2'b01; busy = 1'b1; suspended = 1'b0; target_bit = 1'b1;
    window_open = 1'b0; array_data = 8'h3C; rd_strobe = 1'b0;
    step();
    check("R3 start", {1'b0, dout}, {1'b0, status_of(2'b01, 1'b1, 1'b0, 1'b0, 1'b0)});
    begin
      logic exp_t;
      exp_t = 1'b0;
      for (int n = 0; n < 3; n++) begin
        strobe_read();
        exp_t = !exp_t;
        check("R3 flip", {1'b0, dout}, {1'b0, status_of(2'b01, 1'b1, 1'b0, exp_t, 1'b0)});
        step();  // strobe still held high
        check("R3 held", {1'b0, dout}, {1'b0, status_of(2'b01, 1'b1, 1'b0, exp_t, 1'b0)});
        rd_strobe = 1'b0;
        step();
      end
    end

    // Suspend: strobes ignored, array data visible.
    suspended = 1'b1; array_data = 8'hC3;
    #1;
    check("R10 suspend pass", {rdy, dout}, {1'b1, 8'hC3});
    for (int n = 0; n < 2; n++) begin
      strobe_read();
      rd_strobe = 1'b0;
      step();
    end
    suspended = 1'b0;
    #1;
    check("R5 frozen", {1'b0, dout}, {1'b0, status_of(2'b01, 1'b1, 1'b0, 1'b1, 1'b0)});

    // End of operation clears the toggle.
    busy = 1'b0;
    step();
    busy = 1'b1;
    #1;
    check("R4 restart", {1'b0, dout}, {1'b0, status_of(2'b01, 1'b1, 1'b0, 1'b0, 1'b0)});

    // Sticky error.
    pulse_over = 1'b1;
    step();
    pulse_over = 1'b0;
    #1;
    check("R6 set", {1'b0, dout}, {1'b0, status_of(2'b01, 1'b1, 1'b0, 1'b0, 1'b1)});
    repeat (4) step();
    check("R6 hold", {1'b0, dout}, {1'b0, status_of(2'b01, 1'b1, 1'b0, 1'b0, 1'b1)});
    busy = 1'b0;
    step();
    busy = 1'b1;
    #1;
    check("R6 survives end", {1'b0, dout}, {1'b0, status_of(2'b01, 1'b1, 1'b0, 1'b0, 1'b1)});
    clear_err = 1'b1;
    step();
    clear_err = 1'b0;
    #1;
    check("R6 clear", {1'b0, dout}, {1'b0, status_of(2'b01, 1'b1, 1'b0, 1'b0, 1'b0)});
    pulse_over = 1'b1; clear_err = 1'b1;
    step();
    pulse_over = 1'b0; clear_err = 1'b0;
    #1;
    check("R6 clear wins", {1'b0, dout}, {1'b0, status_of(2'b01, 1'b1, 1'b0, 1'b0, 1'b0)});
    suspended = 1'b1; pulse_over = 1'b1;
    step();
    pulse_over = 1'b0; suspended = 1'b0;
    #1;
    check("R6 no set in suspend", {1'b0, dout}, {1'b0, status_of(2'b01, 1'b1, 1'b0, 1'b0, 1'b0)});

    // Erase window bit and erase polling.
    op_kind = 2'b10; window_open = 1'b1;
    #1;
    check("R7 window open", {1'b0, dout}, {1'b0, 8'h00});
    window_open = 1'b0;
    #1;
    check("R7 window closed", {1'b0, dout}, {1'b0, 8'h08});
    op_kind = 2'b11; target_bit = 1'b0;
    #1;
    check("R2 chip erase poll", {1'b0, dout}, {1'b0, 8'h08});

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule